// File: doc/BRIEF.md
# MII receive frame status tracker

This block sits beside a 4-bit MII receive path and watches the nibble bus, the data-valid line and the receive-error line. It recognises the start of a frame, the start-frame delimiter that ends the preamble, and the end of the frame. While it watches, it counts the preamble nibbles and the frame bytes that follow the delimiter. From these it raises a set of sticky status flags that a host reads and later clears.

Each flag has its own clear input. One error-clear input removes every error flag at once. Three programmable limits apply: the largest allowed preamble length, and the smallest and largest allowed frame length in bytes. Each flag is registered and appears one clock after the edge that sampled its cause. A set event and a clear that meet in the same cycle leave the flag set.

The sequencer has three states. `ST_IDLE` waits for data-valid. `ST_PRE` follows the preamble and hunts for the delimiter. `ST_DATA` counts frame nibbles. The transitions are named as follows:
- IDLE→PRE (`frame_open`): data-valid is sampled high.
- PRE→DATA (`delim_hit`): the delimiter completes.
- PRE→IDLE (`abort_pre`): data-valid drops before any delimiter.
- DATA→IDLE (`frame_close`): data-valid drops after the delimiter.

Top module: `mii_rx_frame_status`

## Requirements
- R1: `sof_flag` rises one clock after data-valid is first sampled high while the tracker is idle.
- R2: Nibbles arrive low nibble first, so the delimiter byte 0xD5 is nibble 0x5 followed by nibble 0xD. When the tracker sees 0x5 then 0xD during the preamble, `sfd_flag` rises one clock after the 0xD nibble. A 0xD nibble with no 0x5 just before it is not a delimiter.
- R3: Every 0x5 nibble before the delimiter's 0xD nibble is counted, including the delimiter's own 0x5. `pre_ovf_err` is set once this count exceeds `max_pre_nibbles`.
- R4: `rx_err_flag` is set when `rx_er` is sampled high while `rx_dv` is high. `rx_er` has no effect while `rx_dv` is low.
- R5: Nibbles are counted only after the delimiter's 0xD nibble. If a frame ends with an odd count of such nibbles, `odd_nib_err` is set.
- R6: `eof_flag` is set when data-valid drops after a frame. If no delimiter was seen, the frame still sets `eof_flag`, but it raises no length error and no odd-nibble error.
- R7: The frame byte count is the post-delimiter nibble count divided by two, rounded down. At frame end after a delimiter, `short_err` is set if the count is below `min_frame_bytes`, and `long_err` is set if the count is above `max_frame_bytes`. A count equal to either limit raises no error.
- R8: `eof_or_err_flag` is set by an end-of-frame event or by any error event. It is cleared by either `clr_eof` or `clr_err`.
- R9: `clr_sof`, `clr_sfd` and `clr_eof` each clear only their own flag (plus `eof_or_err_flag` for `clr_eof`). `clr_err` clears all five error flags. A flag with no clear stays set.
- R10: When a set event and the clear for the same flag occur in one cycle, the flag ends up set.
- R11: After reset, every flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| max_pre_nibbles | input | PCNT_W | Largest allowed count of preamble 0x5 nibbles |
| min_frame_bytes | input | LEN_W | Smallest allowed frame byte count |
| max_frame_bytes | input | LEN_W | Largest allowed frame byte count |
| clr_sof | input | 1 | Clear start-of-frame flag |
| clr_sfd | input | 1 | Clear delimiter flag |
| clr_eof | input | 1 | Clear end-of-frame and combined flag |
| clr_err | input | 1 | Clear all error flags and combined flag |
| sof_flag | output | 1 | Frame started |
| sfd_flag | output | 1 | Delimiter seen |
| eof_flag | output | 1 | Frame ended |
| eof_or_err_flag | output | 1 | End of frame or any error |
| pre_ovf_err | output | 1 | Preamble too long |
| rx_err_flag | output | 1 | MII error during valid data |
| odd_nib_err | output | 1 | Frame ended on odd nibble |
| short_err | output | 1 | Frame below minimum length |
| long_err | output | 1 | Frame above maximum length |

## Verification
The bench targets the off-by-one edges of every limit:
- A preamble of exactly the maximum count and one nibble more. A design that compared with "greater or equal" would flag legal preambles.
- Frames of exactly the minimum and maximum byte counts and one byte past each. A design that rounded the half byte up would misjudge frames that end on an odd nibble.

Frames that never show a delimiter must still close with end-of-frame but no length error. A tracker that left its counters armed would report a spurious short frame for them.

Same-cycle clear and set, and each clear applied on its own, catch two faults:
- a clear priority that drops a fresh event;
- a shared clear that wipes flags it should leave alone.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    localparam int NFLAG    = 9;
    localparam int F_SOF    = 0;
    localparam int F_SFD    = 1;
    localparam int F_EOF    = 2;
    localparam int F_EOE    = 3;
    localparam int F_PREOVF = 4;
    localparam int F_RXERR  = 5;
    localparam int F_ODD    = 6;
    localparam int F_SHORT  = 7;
    localparam int F_LONG   = 8;

    localparam logic [3:0] NIB_PRE   = 4'h5;
    localparam logic [3:0] NIB_DELIM = 4'hD;

endpackage

// File: rtl/mii_rx_seq.sv
module mii_rx_seq
    import mii_rx_pkg::*;
#(
    parameter int PCNT_W = 5,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rxd,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [PCNT_W-1:0] max_pre,
    input  logic [LEN_W-1:0]  min_len,
    input  logic [LEN_W-1:0]  max_len,
    output logic [NFLAG-1:0]  ev
);
    localparam int NIB_W = LEN_W + 1;
    localparam logic [PCNT_W-1:0] PRE_TOP = '1;
    localparam logic [NIB_W-1:0]  NIB_TOP = '1;

    rx_state_e         st, st_nx;
    logic [PCNT_W-1:0] pre_cnt, pre_base, pre_nx;
    logic              last5, last5_nx;
    logic [NIB_W-1:0]  nib_cnt, nib_nx;
    logic [LEN_W-1:0]  byte_cnt;
    logic              in_pre, is5, delim_hit, frame_close, end_any;

    assign is5       = (rxd == NIB_PRE);
    assign in_pre    = rx_dv && (st == ST_IDLE || st == ST_PRE);
    assign delim_hit = rx_dv && (st == ST_PRE) && (rxd == NIB_DELIM) && last5;
    assign frame_close = (st == ST_DATA) && !rx_dv;
    assign end_any   = (st != ST_IDLE) && !rx_dv;
    assign byte_cnt  = nib_cnt[NIB_W-1:1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions: frame_open, delim_hit, abort_pre, frame_close
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (rx_dv)          st_nx = ST_PRE;
            ST_PRE:  if (!rx_dv)         st_nx = ST_IDLE;
                     else if (delim_hit) st_nx = ST_DATA;
            ST_DATA: if (!rx_dv)         st_nx = ST_IDLE;
            default:                     st_nx = ST_IDLE;
        endcase
    end

    // counter next values
    always_comb begin
        pre_base = (st == ST_PRE) ? pre_cnt : '0;
        pre_nx   = pre_base;
        if (in_pre && is5 && pre_base != PRE_TOP) pre_nx = pre_base + PCNT_W'(1);
        last5_nx = in_pre && is5;
        nib_nx   = '0;
        if (st == ST_DATA) begin
            nib_nx = nib_cnt;
            if (rx_dv && nib_cnt != NIB_TOP) nib_nx = nib_cnt + NIB_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            last5   <= 1'b0;
            nib_cnt <= '0;
        end else begin
            pre_cnt <= pre_nx;
            last5   <= last5_nx;
            nib_cnt <= nib_nx;
        end
    end

    // event outputs
    always_comb begin
        ev           = '0;
        ev[F_SOF]    = (st == ST_IDLE) && rx_dv;
        ev[F_SFD]    = delim_hit;
        ev[F_EOF]    = end_any;
        ev[F_PREOVF] = in_pre && is5 && (pre_nx > max_pre);
        ev[F_RXERR]  = rx_dv && rx_er;
        ev[F_ODD]    = frame_close && nib_cnt[0];
        ev[F_SHORT]  = frame_close && (byte_cnt < min_len);
        ev[F_LONG]   = frame_close && (byte_cnt > max_len);
        ev[F_EOE]    = end_any | ev[F_PREOVF] | ev[F_RXERR] | ev[F_ODD]
                     | ev[F_SHORT] | ev[F_LONG];
    end

endmodule

// File: rtl/mii_rx_flag_bank.sv
module mii_rx_flag_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/mii_rx_frame_status.sv
module mii_rx_frame_status
    import mii_rx_pkg::*;
#(
    parameter int PCNT_W = 5,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rxd,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [PCNT_W-1:0] max_pre_nibbles,
    input  logic [LEN_W-1:0]  min_frame_bytes,
    input  logic [LEN_W-1:0]  max_frame_bytes,
    input  logic              clr_sof,
    input  logic              clr_sfd,
    input  logic              clr_eof,
    input  logic              clr_err,
    output logic              sof_flag,
    output logic              sfd_flag,
    output logic              eof_flag,
    output logic              eof_or_err_flag,
    output logic              pre_ovf_err,
    output logic              rx_err_flag,
    output logic              odd_nib_err,
    output logic              short_err,
    output logic              long_err
);
    logic [NFLAG-1:0] ev, clr_vec, flags;

    always_comb begin
        clr_vec           = '0;
        clr_vec[F_SOF]    = clr_sof;
        clr_vec[F_SFD]    = clr_sfd;
        clr_vec[F_EOF]    = clr_eof;
        clr_vec[F_EOE]    = clr_eof | clr_err;
        clr_vec[F_PREOVF] = clr_err;
        clr_vec[F_RXERR]  = clr_err;
        clr_vec[F_ODD]    = clr_err;
        clr_vec[F_SHORT]  = clr_err;
        clr_vec[F_LONG]   = clr_err;
    end

    mii_rx_seq #(.PCNT_W(PCNT_W), .LEN_W(LEN_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .max_pre (max_pre_nibbles),
        .min_len (min_frame_bytes),
        .max_len (max_frame_bytes),
        .ev      (ev)
    );

    mii_rx_flag_bank #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev),
        .clr_i  (clr_vec),
        .flag_o (flags)
    );

    assign sof_flag        = flags[F_SOF];
    assign sfd_flag        = flags[F_SFD];
    assign eof_flag        = flags[F_EOF];
    assign eof_or_err_flag = flags[F_EOE];
    assign pre_ovf_err     = flags[F_PREOVF];
    assign rx_err_flag     = flags[F_RXERR];
    assign odd_nib_err     = flags[F_ODD];
    assign short_err       = flags[F_SHORT];
    assign long_err        = flags[F_LONG];

endmodule

// File: rtl/mii_rx_frame_status_chk.sv
module mii_rx_frame_status_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_dv,
    input logic rx_er,
    input logic clr_sof,
    input logic clr_err,
    input logic sof_flag,
    input logic eof_flag,
    input logic eof_or_err_flag,
    input logic pre_ovf_err,
    input logic rx_err_flag,
    input logic odd_nib_err,
    input logic short_err,
    input logic long_err
);
    a_r1_sof_on_dv_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |=> sof_flag);

    a_r4_rxerr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && rx_er) |=> (rx_err_flag && eof_or_err_flag));

    a_r6_eof_on_dv_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dv) |=> (eof_flag && eof_or_err_flag));

    a_r8_eoe_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        eof_or_err_flag |-> (eof_flag || pre_ovf_err || rx_err_flag
                             || odd_nib_err || short_err || long_err));

    a_r9_sof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_flag && !clr_sof) |=> sof_flag);

    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !rx_dv && !$past(rx_dv)) |=>
        !(pre_ovf_err || rx_err_flag || odd_nib_err || short_err || long_err));
endmodule

bind mii_rx_frame_status mii_rx_frame_status_chk u_chk (.*);

// File: tb/sim_mii_rx_frame_status.sv
module sim_mii_rx_frame_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rxd = 4'h0;
    logic        rx_dv = 1'b0, rx_er = 1'b0;
    logic [4:0]  max_pre_nibbles = 5'd15;
    logic [10:0] min_frame_bytes = 11'd4;
    logic [10:0] max_frame_bytes = 11'd10;
    logic        clr_sof = 1'b0, clr_sfd = 1'b0, clr_eof = 1'b0, clr_err = 1'b0;
    logic        sof_flag, sfd_flag, eof_flag, eof_or_err_flag;
    logic        pre_ovf_err, rx_err_flag, odd_nib_err, short_err, long_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mii_rx_frame_status u0 (.*);

    // flag order: {long, short, odd, rxerr, preovf, eoe, eof, sfd, sof}
    function automatic logic [8:0] got();
        return {long_err, short_err, odd_nib_err, rx_err_flag, pre_ovf_err,
                eof_or_err_flag, eof_flag, sfd_flag, sof_flag};
    endfunction

    task automatic check(input logic [8:0] exp, input string what);
        checks++;
        if (got() !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", what, got(), exp);
        end
    endtask

    task automatic drive(input logic [3:0] d, input logic v, input logic e);
        rxd = d; rx_dv = v; rx_er = e;
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_sof = 1'b1; clr_sfd = 1'b1; clr_eof = 1'b1; clr_err = 1'b1;
        rx_dv = 1'b0; rx_er = 1'b0;
        @(negedge clk);
        clr_sof = 1'b0; clr_sfd = 1'b0; clr_eof = 1'b0; clr_err = 1'b0;
    endtask

    task automatic send_frame(input int npre, input int nbytes, input bit odd,
                              input bit er_en, input int er_at);
        for (int i = 0; i < npre; i++) drive(4'h5, 1'b1, 1'b0);
        drive(4'hD, 1'b1, 1'b0);
        for (int i = 0; i < nbytes * 2 + int'(odd); i++)
            drive(4'hA, 1'b1, er_en && (i == er_at));
        drive(4'h0, 1'b0, 1'b0);
    endtask

    // {npre, nbytes, odd, er_en, er_at, expected flags}; limits pre 15, len 4..10
    localparam logic [31:0] VEC [12] = '{
        {8'd15, 8'd6,  1'b0, 1'b0, 5'd0, 9'b000001111},  // R1 R2 R6 R8 nominal
        {8'd16, 8'd6,  1'b0, 1'b0, 5'd0, 9'b000011111},  // R3 one over limit
        {8'd15, 8'd4,  1'b0, 1'b0, 5'd0, 9'b000001111},  // R7 at minimum
        {8'd15, 8'd3,  1'b0, 1'b0, 5'd0, 9'b010001111},  // R7 below minimum
        {8'd15, 8'd10, 1'b0, 1'b0, 5'd0, 9'b000001111},  // R7 at maximum
        {8'd15, 8'd11, 1'b0, 1'b0, 5'd0, 9'b100001111},  // R7 above maximum
        {8'd15, 8'd6,  1'b1, 1'b0, 5'd0, 9'b001001111},  // R5 odd nibble
        {8'd15, 8'd6,  1'b0, 1'b1, 5'd3, 9'b000101111},  // R4 error in data
        {8'd0,  8'd6,  1'b0, 1'b0, 5'd0, 9'b000001101},  // R6 no delimiter
        {8'd1,  8'd4,  1'b0, 1'b0, 5'd0, 9'b000001111},  // R2 single 0x5
        {8'd3,  8'd0,  1'b0, 1'b0, 5'd0, 9'b010001111},  // R7 empty frame
        {8'd15, 8'd3,  1'b1, 1'b0, 5'd0, 9'b011001111}   // R5 R7 odd and short
    };

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(9'b0, "R11 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(9'b0, "R11 idle after reset");

        for (int k = 0; k < 12; k++) begin
            clear_all();
            send_frame(int'(VEC[k][31:24]), int'(VEC[k][23:16]), VEC[k][15],
                       VEC[k][14], int'(VEC[k][13:9]));
            check(VEC[k][8:0], $sformatf("R1..R8 table row %0d", k));
        end

        // R1 / R2 timing inside a frame
        clear_all();
        drive(4'h5, 1'b1, 1'b0);
        check(9'b000000001, "R1 sof one clock after dv");
        drive(4'hD, 1'b1, 1'b0);
        check(9'b000000011, "R2 sfd one clock after 0xD nibble");
        for (int i = 0; i < 8; i++) drive(4'hA, 1'b1, 1'b0);
        drive(4'h0, 1'b0, 1'b0);

        // R2: 0xD without a preceding 0x5 is not a delimiter
        clear_all();
        drive(4'h7, 1'b1, 1'b0);
        drive(4'hD, 1'b1, 1'b0);
        check(9'b000000001, "R2 lone 0xD ignored");
        drive(4'h0, 1'b0, 1'b0);

        // R4: rx_er with dv low has no effect
        clear_all();
        drive(4'h0, 1'b0, 1'b1);
        drive(4'h0, 1'b0, 1'b1);
        check(9'b0, "R4 rx_er ignored when dv low");
        rx_er = 1'b0;

        // R9: individual clears
        clear_all();
        send_frame(16, 3, 1'b1, 1'b1, 0);
        check(9'b011111111, "R9 all-flag frame");
        clr_sof = 1'b1; @(negedge clk); clr_sof = 1'b0;
        check(9'b011111110, "R9 clr_sof alone");
        clr_sfd = 1'b1; @(negedge clk); clr_sfd = 1'b0;
        check(9'b011111100, "R9 clr_sfd alone");
        clr_eof = 1'b1; @(negedge clk); clr_eof = 1'b0;
        check(9'b011110000, "R9 clr_eof keeps errors");
        send_frame(16, 3, 1'b1, 1'b1, 0);
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
        check(9'b000000111, "R9 clr_err clears errors and combined");

        // R10: set beats clear in the same cycle
        clear_all();
        clr_sof = 1'b1;
        drive(4'h5, 1'b1, 1'b0);
        clr_sof = 1'b0;
        check(9'b000000001, "R10 sof set wins over clr_sof");
        drive(4'hD, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) drive(4'hA, 1'b1, 1'b0);
        clr_eof = 1'b1;
        drive(4'h0, 1'b0, 1'b0);
        clr_eof = 1'b0;
        check(9'b000001111, "R10 eof set wins over clr_eof");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule